// File: doc/BRIEF.md
# CPU Halt/Step Debug Port

This block gives an external bus master control over a small soft CPU core through a window of two bus words. The low word holds commands and status. The high word is a data port into the core's general registers and its program counter. Through these two words a host can stop the core, let it run, pulse its reboot input, or release it for exactly one retired instruction. While the core is stopped, the host can also read and change its architectural state.

The core leaves reset stopped. This lets memory and registers be loaded before the first instruction runs. Each request carries a flag naming the master that issued it. A request flagged as coming from the CPU itself is refused with an error response and has no effect. Only an outside master can therefore steer the core. Every request gets exactly one response in the clock cycle after it is presented.

Top module: `dbg_port`

## Requirements
- R1: After reset the halt request is set, `core_halt` is high, `core_reset` is low, the sticky error is clear and the register index is 0, so a control read returns 0x9 while the core reports stopped.
- R2: A host write to the control word (`bus_addr`=0) with bit 0 cleared drops `core_halt` after that clock edge, and one with bit 0 set raises it again. After the core reports stopped, no further instruction retires.
- R3: A host control write with bit 1 set, issued while the status bit (bit 3, a copy of `core_halted`) reads 1 and no single step is in flight, releases the core for exactly one retired instruction and then stops it again. In every other case the step bit has no effect.
- R4: A host control write with bit 2 set gives a `core_reset` pulse exactly one cycle long and leaves the halt request unchanged. Bits 1 and 2 read back as 0.
- R5: A host read of the data word (`bus_addr`=1) is acknowledged in the next cycle. It carries the core register selected by control bits 12:8: index 31 selects the program counter, and lower indexes select general registers.
- R6: A host write of the data word while `core_halted` is high writes `bus_wdata` into the selected core register in the same cycle.
- R7: A host write of the data word while `core_halted` is low changes no core register and sets the sticky error (control bit 4). A control write with bit 4 set clears it.
- R8: Any request with `bus_from_cpu` high is answered in the next cycle with `bus_err` high, `bus_ack` low and zero read data. It changes no state: halt, index, error, core registers and reset pulse are all unaffected.
- R9: Each host request is answered in the next cycle by `bus_ack` alone. A cycle with no request is followed by neither `bus_ack` nor `bus_err`. Write responses carry zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Request to one of the two debug words this cycle |
| bus_addr | input | 1 | 0 selects the control word, 1 the data word |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_wdata | input | DATA_W | Write data |
| bus_from_cpu | input | 1 | Request was issued by the debugged core itself |
| bus_ack | output | 1 | Successful response, one cycle after the request |
| bus_err | output | 1 | Refused response, one cycle after the request |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ack` |
| core_halt | output | 1 | Stop request to the core |
| core_reset | output | 1 | One-cycle reboot pulse to the core |
| core_halted | input | 1 | Core reports it is stopped |
| core_retire | input | 1 | Core retires an instruction this cycle |
| rf_idx | output | IDX_W | Register selector for the side port |
| rf_we | output | 1 | Side-port write strobe |
| rf_wdata | output | DATA_W | Side-port write data |
| rf_rdata | input | DATA_W | Side-port read data, combinational in `rf_idx` |

## Verification
The assertions assume that the core retires an instruction in the first cycle after `core_halt` drops. They also assume it raises `core_halted` only in response to `core_halt`, and that the bus presents at most one request per cycle. The bench core stub retires one instruction in every cycle `core_halt` is low and registers `core_halted` from it. The driver holds each request for exactly one cycle. Back-to-back step commands and reset commands are spaced so that the single-cycle pulse checks refer to one command each.

// File: rtl/dbg_port.sv
module dbg_port #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_from_cpu,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_halt,
  output logic              core_reset,
  input  logic              core_halted,
  input  logic              core_retire,
  output logic [IDX_W-1:0]  rf_idx,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam int HALT_B = 0;
  localparam int STEP_B = 1;
  localparam int RST_B  = 2;
  localparam int ERR_B  = 4;
  localparam int IDX_LO = 8;
  localparam int PAD_W  = DATA_W - IDX_LO - IDX_W;

  logic             halt_req, stepping, err_q;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W-1:0] ctl_word;

  wire host   = bus_sel & ~bus_from_cpu;
  wire ctl_wr = host &  bus_we & ~bus_addr;
  wire ctl_rd = host & ~bus_we & ~bus_addr;
  wire dat_wr = host &  bus_we &  bus_addr;
  wire dat_rd = host & ~bus_we &  bus_addr;
  wire step_ok = ctl_wr & bus_wdata[STEP_B] & core_halted & ~stepping;

  assign ctl_word = {{PAD_W{1'b0}}, idx_q, 3'b000, err_q, core_halted, 2'b00, halt_req};

  assign core_halt = halt_req & ~stepping;
  assign rf_idx    = idx_q;
  assign rf_we     = dat_wr & core_halted;
  assign rf_wdata  = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req   <= 1'b1;
      stepping   <= 1'b0;
      err_q      <= 1'b0;
      idx_q      <= '0;
      core_reset <= 1'b0;
      bus_ack    <= 1'b0;
      bus_err    <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_ack    <= host;
      bus_err    <= bus_sel & bus_from_cpu;
      bus_rdata  <= ctl_rd ? ctl_word : (dat_rd ? rf_rdata : '0);
      core_reset <= ctl_wr & bus_wdata[RST_B];
      if (ctl_wr) begin
        halt_req <= bus_wdata[HALT_B];
        idx_q    <= bus_wdata[IDX_LO +: IDX_W];
      end
      if (step_ok)
        stepping <= 1'b1;
      else if (core_retire)
        stepping <= 1'b0;
      if (dat_wr & ~core_halted)
        err_q <= 1'b1;
      else if (ctl_wr & bus_wdata[ERR_B])
        err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_port_chk.sv
module dbg_port_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_from_cpu,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              core_halt,
  input logic              core_reset,
  input logic              core_halted
);
  AST_HALT_IN_RESET: assert property (@(posedge clk) !rst_n |=> core_halt); // R1
  AST_RUN_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_halt) |-> $past(bus_sel && !bus_from_cpu && bus_we && !bus_addr)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_from_cpu && bus_we && !bus_addr && bus_wdata[1] && bus_wdata[0]
     && core_halt && core_halted) |=> !core_halt ##1 core_halt); // R3
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> $past(bus_sel && !bus_from_cpu && bus_we && !bus_addr && bus_wdata[2])); // R4
  AST_CPU_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_from_cpu) |=> (bus_err && !bus_ack)); // R8
  AST_HOST_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_from_cpu) |=> (bus_ack && !bus_err)); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> (!bus_ack && !bus_err)); // R9
endmodule

bind dbg_port dbg_port_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_dbg_port.sv
module test_dbg_port;
  localparam int DW = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_addr = 1'b0, bus_we = 1'b0, bus_from_cpu = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_ack, bus_err, core_halt, core_reset, rf_we;
  logic [DW-1:0] bus_rdata, rf_wdata, rf_rdata;
  logic [IW-1:0] rf_idx;
  logic core_halted;
  logic core_retire;

  always #2.5 clk = ~clk;

  dbg_port #(.DATA_W(DW), .IDX_W(IW)) i_dbg_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_from_cpu(bus_from_cpu), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .core_halt(core_halt), .core_reset(core_reset),
    .core_halted(core_halted), .core_retire(core_retire), .rf_idx(rf_idx), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

  // core stub
  logic [DW-1:0] regs [16];
  logic [DW-1:0] pc;
  int unsigned   retired;
  assign core_retire = ~core_halt;
  assign rf_rdata = (rf_idx == 5'd31) ? pc : regs[rf_idx[3:0]];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_halted <= 1'b1;
      pc <= '0;
      retired <= 0;
      for (int i = 0; i < 16; i++) regs[i] <= '0;
    end else begin
      core_halted <= core_halt;
      if (core_reset) pc <= '0;
      else if (core_retire) begin pc <= pc + 4; retired <= retired + 1; end
      else if (rf_we && rf_idx == 5'd31) pc <= rf_wdata;
      if (rf_we && rf_idx != 5'd31) regs[rf_idx[3:0]] <= rf_wdata;
    end
  end

  int checks = 0, fails = 0, rst_pulses = 0;
  bit done = 1'b0;

  typedef struct { bit e_err; logic [DW-1:0] e_data; string tag; } item_t;
  item_t sb[$];

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(bit cpu, bit addr, bit we, logic [DW-1:0] wd,
                        bit e_err, logic [DW-1:0] e_data, string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_from_cpu = cpu; bus_addr = addr; bus_we = we; bus_wdata = wd;
    it.e_err = e_err; it.e_data = e_data; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_sel = 1'b0; bus_from_cpu = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (core_reset) rst_pulses++;
    if (sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      chk(bus_ack == !it.e_err && bus_err == it.e_err, {it.tag, " response kind"},
          {30'd0, bus_err, bus_ack}, {30'd0, it.e_err, !it.e_err});
      chk(bus_rdata == it.e_data, {it.tag, " data"}, bus_rdata, it.e_data);
    end else if (rst_n && (bus_ack || bus_err)) begin
      chk(1'b0, "R9 stray response", {30'd0, bus_err, bus_ack}, '0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", '0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned base;
    idle(3);
    chk(core_halt == 1'b1 && core_reset == 1'b0, "R1 halted in reset", {30'd0, core_reset, core_halt}, 32'd1);
    rst_n = 1'b1;
    idle(2);
    chk(core_halt == 1'b1, "R1 halted after reset", {31'd0, core_halt}, 32'd1);
    bus_op(0, 0, 0, '0, 0, 32'h9, "R1 control readback");

    // register access while stopped
    bus_op(0, 0, 1, 32'h0501, 0, '0, "R9 control write");
    bus_op(0, 1, 1, 32'hA5A5, 0, '0, "R6 data write");
    chk(regs[5] == 32'hA5A5, "R6 register written", regs[5], 32'hA5A5);
    bus_op(0, 1, 0, '0, 0, 32'hA5A5, "R5 data read r5");
    bus_op(0, 0, 1, 32'h1F01, 0, '0, "R5 select pc");
    bus_op(0, 1, 1, 32'h100, 0, '0, "R6 pc write");
    bus_op(0, 1, 0, '0, 0, 32'h100, "R5 pc read");

    // single step
    base = retired;
    bus_op(0, 0, 1, 32'h1F03, 0, '0, "R3 step");
    idle(4);
    chk(retired == base + 1, "R3 one retire", retired, base + 1);
    chk(core_halt == 1'b1, "R3 stopped again", {31'd0, core_halt}, 32'd1);
    bus_op(0, 1, 0, '0, 0, 32'h104, "R3 pc advanced");
    base = retired;
    bus_op(0, 0, 1, 32'h1F03, 0, '0, "R3 step a");
    bus_op(0, 0, 1, 32'h1F03, 0, '0, "R3 step b ignored");
    idle(4);
    chk(retired == base + 1, "R3 back-to-back step once", retired, base + 1);
    bus_op(0, 0, 1, 32'h1F03, 0, '0, "R3 step again");
    idle(4);
    chk(retired == base + 2, "R3 later step accepted", retired, base + 2);

    // reboot pulse
    bus_op(0, 0, 1, 32'h1F05, 0, '0, "R4 reset command");
    idle(3);
    chk(rst_pulses == 1, "R4 single pulse", rst_pulses, 1);
    chk(core_halt == 1'b1, "R4 halt kept", {31'd0, core_halt}, 32'd1);
    bus_op(0, 0, 0, '0, 0, 32'h1F09, "R4 control bits read 0");
    bus_op(0, 1, 0, '0, 0, 32'h0, "R4 pc cleared");

    // run, write refused while running
    base = retired;
    bus_op(0, 0, 1, 32'h0300, 0, '0, "R2 run");
    idle(10);
    chk(retired > base + 5, "R2 core runs", retired, base + 10);
    bus_op(0, 0, 0, '0, 0, 32'h0300, "R2 status running");
    bus_op(0, 1, 1, 32'hDEAD, 0, '0, "R7 data write while running");
    chk(regs[3] == 32'h0, "R7 register untouched", regs[3], 32'h0);
    bus_op(0, 0, 0, '0, 0, 32'h0310, "R7 sticky error set");
    bus_op(0, 0, 1, 32'h0301, 0, '0, "R2 halt");
    idle(2);
    base = retired;
    idle(5);
    chk(retired == base, "R2 no retire while stopped", retired, base);
    bus_op(0, 0, 0, '0, 0, 32'h0319, "R7 error still set");
    bus_op(0, 0, 1, 32'h0311, 0, '0, "R7 clear error");
    bus_op(0, 0, 0, '0, 0, 32'h0309, "R7 error cleared");

    // self access from the core
    base = retired;
    bus_op(1, 0, 1, 32'h1F04, 1, '0, "R8 cpu control write");
    bus_op(1, 1, 1, 32'hBEEF, 1, '0, "R8 cpu data write");
    bus_op(1, 1, 0, '0, 1, '0, "R8 cpu data read");
    idle(3);
    chk(core_halt == 1'b1 && retired == base, "R8 core still stopped", retired, base);
    chk(rst_pulses == 1, "R8 no reset pulse", rst_pulses, 1);
    chk(regs[3] == 32'h0, "R8 register untouched", regs[3], 32'h0);
    bus_op(0, 0, 0, '0, 0, 32'h0309, "R8 control unchanged");

    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule